// File: doc/BRIEF.md
# Pin Interrupt Aggregator

This block collects interrupt requests from a parameterized set of external pins and merges them into one interrupt line for a processor. Each pin can be set up to respond to a level or to an edge, with either polarity. Software can also raise a pin's request itself, can mask the pin, and can leave the pin out of the controller altogether. Pins are organised in ports of 32, and each 32-bit word in every register window covers one port.

Software programs the pins through a simple word-addressed register bus. Apart from domain-enable, every control field is changed only through a pair of aliases: one sets bits and one clears them, in each case for the bits written as 1. A register write therefore never has to be a read-modify-write. The combined output is raised while any unmasked pin reports status. An interrupt handler reads status one port at a time and acknowledges edge events by writing ones.

Top module: `eint_ctrl`

## Requirements
- R1: After reset, every implemented mask bit is 1. All domain-enable, sensitivity, polarity, soft and pending bits are 0, and `irq_o` is low.
- R2: Byte offset bits [10:6] select the register window: 0x000 status, 0x040 ack, 0x080 mask, 0x0C0 mask-set, 0x100 mask-clear, 0x140 sensitivity, 0x180 sens-set, 0x1C0 sens-clear, 0x200 soft, 0x240 soft-set, 0x280 soft-clear, 0x300 polarity, 0x340 pol-set, 0x380 pol-clear, 0x400 domain-enable. Pin p sits in word p/32 (offset + 4*(p/32)) at bit p mod 32. Bits and words beyond the pin count read 0 and ignore writes.
- R3: Writing a 1 to a set alias sets that bit, writing a 1 to a clear alias clears it, and 0 bits leave the bit unchanged. Writes to the base address of the mask, sensitivity, soft or polarity register have no effect.
- R4: Domain-enable is written and read directly. A pin whose domain-enable bit is 0 reports status 0, including for a soft request, and latches no edge.
- R5: With sensitivity 1 (level), status equals the synchronized input when polarity is 1, and its inverse when polarity is 0. A change on the pin shows on `irq_o` two clock edges after it reaches the input.
- R6: With sensitivity 0 (edge), a rising edge (polarity 1) or a falling edge (polarity 0) latches pending status. The status stays set after the input returns and shows on `irq_o` three clock edges after the input changes. The opposite edge latches nothing.
- R7: Writing a 1 to an ack bit clears that pin's pending edge status, and 0 bits have no effect. If an edge latches in the same cycle as the ack, the new edge is kept.
- R8: A soft bit set through soft-set raises that pin's status in either mode until it is cleared through soft-clear.
- R9: `irq_o` is high exactly when some pin has status 1 and mask 0.
- R10: `rdata` holds the addressed word one clock after `rd_en`. The ack window and all set and clear aliases read 0.
- R11: Changing polarity on an edge-mode pin whose input is steady latches no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 9 | Word address, byte offset bits [10:2] |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one cycle after rd_en |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench checks the exact edge on which level and edge events reach `irq_o`. A design with a synchronizer stage too many or too few fails those checks. It writes an ack in the very cycle an edge latches: a design that lets the ack win drops a real event. It toggles polarity on a steady edge-mode input, which catches a detector that compares polarity-adjusted levels and invents an edge. It writes zeros to aliases and ack, targets a partial second port and the base addresses of aliased registers, and raises soft requests on a pin outside the domain. A design that treats these as full writes, or that lets a soft request bypass domain-enable, fails there.

// File: rtl/eint_pkg.sv
package eint_pkg;
   localparam int WORD_W = 32;

   localparam logic [4:0] SEL_STAT     = 5'd0;
   localparam logic [4:0] SEL_ACK      = 5'd1;
   localparam logic [4:0] SEL_MASK     = 5'd2;
   localparam logic [4:0] SEL_MASK_SET = 5'd3;
   localparam logic [4:0] SEL_MASK_CLR = 5'd4;
   localparam logic [4:0] SEL_SENS     = 5'd5;
   localparam logic [4:0] SEL_SENS_SET = 5'd6;
   localparam logic [4:0] SEL_SENS_CLR = 5'd7;
   localparam logic [4:0] SEL_SOFT     = 5'd8;
   localparam logic [4:0] SEL_SOFT_SET = 5'd9;
   localparam logic [4:0] SEL_SOFT_CLR = 5'd10;
   localparam logic [4:0] SEL_POL      = 5'd12;
   localparam logic [4:0] SEL_POL_SET  = 5'd13;
   localparam logic [4:0] SEL_POL_CLR  = 5'd14;
   localparam logic [4:0] SEL_DOM      = 5'd16;

   function automatic logic [WORD_W-1:0] port_valid(int pins, int port);
      logic [WORD_W-1:0] v;
      for (int i = 0; i < WORD_W; i++) v[i] = ((port * WORD_W + i) < pins);
      return v;
   endfunction

   function automatic logic [WORD_W-1:0] set_clr(logic [WORD_W-1:0] cur,
                                                 logic do_set, logic do_clr,
                                                 logic [WORD_W-1:0] bits);
      logic [WORD_W-1:0] nxt;
      nxt = cur;
      if (do_set) nxt = nxt | bits;
      if (do_clr) nxt = nxt & ~bits;
      return nxt;
   endfunction
endpackage

// File: rtl/eint_sync.sv
module eint_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("eint_sync needs at least two stages");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d_i;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/eint_port.sv
module eint_port
   import eint_pkg::*;
#(
   parameter logic [31:0] VALID = 32'hFFFF_FFFF
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_hit,
   input  logic [4:0]  sel,
   input  logic [31:0] wdata,
   input  logic [31:0] pin_s,
   output logic [31:0] mask_q,
   output logic [31:0] sens_q,
   output logic [31:0] pol_q,
   output logic [31:0] soft_q,
   output logic [31:0] dom_q,
   output logic [31:0] pend_q,
   output logic [31:0] stat_o,
   output logic [31:0] rd_o,
   output logic        req_o
);
   logic [31:0] bits;
   logic [31:0] prev_q;
   logic [31:0] rise, fall, hit, ack, lvl;

   assign bits = wdata & VALID;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= VALID;
         sens_q <= '0;
         pol_q  <= '0;
         soft_q <= '0;
         dom_q  <= '0;
      end else begin
         mask_q <= set_clr(mask_q, wr_hit && sel == SEL_MASK_SET,
                           wr_hit && sel == SEL_MASK_CLR, bits);
         sens_q <= set_clr(sens_q, wr_hit && sel == SEL_SENS_SET,
                           wr_hit && sel == SEL_SENS_CLR, bits);
         pol_q  <= set_clr(pol_q, wr_hit && sel == SEL_POL_SET,
                           wr_hit && sel == SEL_POL_CLR, bits);
         soft_q <= set_clr(soft_q, wr_hit && sel == SEL_SOFT_SET,
                           wr_hit && sel == SEL_SOFT_CLR, bits);
         if (wr_hit && sel == SEL_DOM) dom_q <= bits;
      end
   end

   // edge detection on raw synchronized levels, polarity only picks the edge
   assign rise = pin_s & ~prev_q;
   assign fall = ~pin_s & prev_q;
   assign hit  = ((pol_q & rise) | (~pol_q & fall)) & ~sens_q & dom_q & VALID;
   assign ack  = (wr_hit && sel == SEL_ACK) ? bits : '0;
   assign lvl  = pin_s ~^ pol_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         pend_q <= '0;
      end else begin
         prev_q <= pin_s & VALID;
         pend_q <= (pend_q & ~ack) | hit;
      end
   end

   assign stat_o = dom_q & VALID & (soft_q | (sens_q & lvl) | (~sens_q & pend_q));
   assign req_o  = |(stat_o & ~mask_q);

   always_comb begin
      unique case (sel)
         SEL_STAT: rd_o = stat_o;
         SEL_MASK: rd_o = mask_q;
         SEL_SENS: rd_o = sens_q;
         SEL_SOFT: rd_o = soft_q;
         SEL_POL:  rd_o = pol_q;
         SEL_DOM:  rd_o = dom_q;
         default:  rd_o = '0;
      endcase
   end
endmodule

// File: rtl/eint_ctrl.sv
module eint_ctrl
   import eint_pkg::*;
#(
   parameter int NUM_PINS    = 40,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                wr_en,
   input  logic                rd_en,
   input  logic [10:2]         addr,
   input  logic [31:0]         wdata,
   output logic [31:0]         rdata,
   output logic                irq_o
);
   localparam int NUM_PORTS = (NUM_PINS + WORD_W - 1) / WORD_W;
   localparam int PAD       = NUM_PORTS * WORD_W;

   if (NUM_PINS < 1 || NUM_PINS > 512) begin : g_bad_pins
      $error("NUM_PINS must lie in 1..512 (16 words per window)");
   end

   logic [4:0]     sel;
   logic [3:0]     word;
   logic [PAD-1:0] pin_pad, pin_s;
   logic [PAD-1:0] mask_v, sens_v, pol_v, soft_v, dom_v, pend_v, stat_v;
   logic [31:0]    rd_word [NUM_PORTS];
   logic [NUM_PORTS-1:0] req_v;
   logic [31:0]    rd_mux;

   assign sel  = addr[10:6];
   assign word = addr[5:2];

   assign pin_pad[NUM_PINS-1:0] = pin_i;
   if (PAD > NUM_PINS) begin : g_pad
      assign pin_pad[PAD-1:NUM_PINS] = '0;
   end

   eint_sync #(.WIDTH(PAD), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_pad),
      .q_o   (pin_s)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      eint_port #(.VALID(port_valid(NUM_PINS, p))) u_port (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_hit (wr_en && (int'(word) == p)),
         .sel    (sel),
         .wdata  (wdata),
         .pin_s  (pin_s[p*WORD_W +: WORD_W]),
         .mask_q (mask_v[p*WORD_W +: WORD_W]),
         .sens_q (sens_v[p*WORD_W +: WORD_W]),
         .pol_q  (pol_v[p*WORD_W +: WORD_W]),
         .soft_q (soft_v[p*WORD_W +: WORD_W]),
         .dom_q  (dom_v[p*WORD_W +: WORD_W]),
         .pend_q (pend_v[p*WORD_W +: WORD_W]),
         .stat_o (stat_v[p*WORD_W +: WORD_W]),
         .rd_o   (rd_word[p]),
         .req_o  (req_v[p])
      );
   end

   always_comb begin
      rd_mux = '0;
      for (int p = 0; p < NUM_PORTS; p++)
         if (int'(word) == p) rd_mux = rd_word[p];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rdata <= '0;
      else if (rd_en) rdata <= rd_mux;
   end

   assign irq_o = |req_v;
endmodule

// File: rtl/eint_ctrl_chk.sv
module eint_ctrl_chk
   import eint_pkg::*;
#(
   parameter int NUM_PINS = 40
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_en,
   input logic [10:2]   addr,
   input logic [31:0]   wdata,
   input logic          irq_o,
   input logic [((NUM_PINS+31)/32)*32-1:0] mask_v,
   input logic [((NUM_PINS+31)/32)*32-1:0] sens_v,
   input logic [((NUM_PINS+31)/32)*32-1:0] pol_v,
   input logic [((NUM_PINS+31)/32)*32-1:0] soft_v,
   input logic [((NUM_PINS+31)/32)*32-1:0] dom_v,
   input logic [((NUM_PINS+31)/32)*32-1:0] pend_v,
   input logic [((NUM_PINS+31)/32)*32-1:0] stat_v,
   input logic [((NUM_PINS+31)/32)*32-1:0] pin_s
);
   localparam logic [31:0] VALID0 = port_valid(NUM_PINS, 0);

   logic w0_mset, w0_mclr, ack_wr;
   assign w0_mset = wr_en && addr[10:6] == SEL_MASK_SET && addr[5:2] == 4'd0;
   assign w0_mclr = wr_en && addr[10:6] == SEL_MASK_CLR && addr[5:2] == 4'd0;
   assign ack_wr  = wr_en && addr[10:6] == SEL_ACK;

   AST_MASK_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      w0_mset |=> ((mask_v[31:0] & $past(wdata) & VALID0) == ($past(wdata) & VALID0))); // R3
   AST_MASK_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      w0_mclr |=> ((mask_v[31:0] & $past(wdata) & VALID0) == 32'd0)); // R3
   AST_DOMAIN_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_v & ~dom_v) == '0)); // R4
   AST_LEVEL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      ((dom_v & sens_v & ~soft_v & (stat_v ^ (pin_s ~^ pol_v))) == '0)); // R5
   AST_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_wr |=> (($past(pend_v) & ~pend_v) == '0)); // R7
   AST_SOFT_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
      ((soft_v & dom_v & ~stat_v) == '0)); // R8
   AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_v & ~mask_v) == '0) |-> !irq_o); // R9
   AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
      ((stat_v & ~mask_v) != '0) |-> irq_o); // R9
endmodule

bind eint_ctrl eint_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .wr_en  (wr_en),
   .addr   (addr),
   .wdata  (wdata),
   .irq_o  (irq_o),
   .mask_v (mask_v),
   .sens_v (sens_v),
   .pol_v  (pol_v),
   .soft_v (soft_v),
   .dom_v  (dom_v),
   .pend_v (pend_v),
   .stat_v (stat_v),
   .pin_s  (pin_s)
);

// File: tb/tb_eint_ctrl.sv
`timescale 1ns/1ps
module tb_eint_ctrl;
   localparam int NP = 40;

   localparam logic [10:0] A_STAT = 11'h000, A_ACK = 11'h040, A_MASK = 11'h080,
      A_MSET = 11'h0C0, A_MCLR = 11'h100, A_SENS = 11'h140, A_SSET = 11'h180,
      A_SOFT = 11'h200, A_FSET = 11'h240, A_FCLR = 11'h280, A_POL = 11'h300,
      A_PSET = 11'h340, A_PCLR = 11'h380, A_DOM = 11'h400;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_i = '0;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [10:2]   addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic          irq_o;

   int n_chk = 0, n_err = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic        rd_fire = 1'b0;

   always #2 clk = ~clk;

   eint_ctrl #(.NUM_PINS(NP)) dut (
      .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o)
   );

   // monitor: pops expected read data as the design returns it
   always @(posedge clk) rd_fire <= rd_en;
   always @(negedge clk) begin
      if (rd_fire && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         n_chk++;
         if (rdata !== e) begin
            n_err++;
            $display("FAIL %s: rdata=%h expected %h", t, rdata, e);
         end
      end
   end

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [10:0] a, logic [31:0] d);
      wr_en = 1'b1; addr = a[10:2]; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [10:0] a, logic [31:0] e, string t);
      rd_en = 1'b1; addr = a[10:2];
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic chk_irq(logic e, string t);
      n_chk++;
      if (irq_o !== e) begin
         n_err++;
         $display("FAIL %s: irq_o=%b expected %b", t, irq_o, e);
      end
   endtask

   initial begin
      tick(3);
      rst_n = 1'b1;
      tick(1);
      // R1 reset state
      chk_irq(1'b0, "R1 irq after reset");
      rd(A_MASK, 32'hFFFF_FFFF, "R1 mask word0");
      rd(A_MASK + 11'h4, 32'h0000_00FF, "R1 mask word1 partial");
      rd(A_DOM, 32'h0, "R1 domain word0");
      rd(A_STAT, 32'h0, "R1 status word0");
      // R3 aliases and base-address writes
      wr(A_MCLR, 32'h0000_00F0);
      wr(A_MSET, 32'h0000_0010);
      wr(A_MASK, 32'h0);
      rd(A_MASK, 32'hFFFF_FF1F, "R3 mask set/clr, base write ignored");
      wr(A_MSET + 11'h4, 32'hFFFF_FFFF);
      rd(A_MASK + 11'h4, 32'h0000_00FF, "R2 unimplemented bits read 0");
      rd(A_MASK + 11'hC, 32'h0, "R2 unimplemented word reads 0");
      // R4 domain enable
      wr(A_DOM, 32'h0000_000F);
      rd(A_DOM, 32'h0000_000F, "R4 domain readback");
      wr(A_DOM + 11'h4, 32'hFFFF_FFFF);
      rd(A_DOM + 11'h4, 32'h0000_00FF, "R4 domain word1");
      // R5 level mode on pin 0
      wr(A_PSET, 32'h1);
      wr(A_SSET, 32'h1);
      wr(A_MCLR, 32'h1);
      rd(A_SENS, 32'h1, "R3 sens-set");
      rd(A_POL, 32'h1, "R3 pol-set");
      rd(A_SSET, 32'h0, "R10 alias reads 0");
      pin_i[0] = 1'b1;
      tick(1); chk_irq(1'b0, "R5 level not after one edge");
      tick(1); chk_irq(1'b1, "R5 level after two edges");
      rd(A_STAT, 32'h1, "R5 level active high");
      pin_i[0] = 1'b0; tick(3);
      rd(A_STAT, 32'h0, "R5 level follows low");
      wr(A_PCLR, 32'h1);
      rd(A_STAT, 32'h1, "R5 active low");
      wr(A_MSET, 32'h1);
      chk_irq(1'b0, "R9 masked pin quiet");
      rd(A_STAT, 32'h1, "R9 status unaffected by mask");
      wr(A_DOM, 32'h0000_000E);
      rd(A_STAT, 32'h0, "R4 disabled pin status 0");
      // R6 edge mode
      wr(A_PSET, 32'h2);
      wr(A_MCLR, 32'h6);
      pin_i[1] = 1'b1;
      tick(1); chk_irq(1'b0, "R6 edge after one");
      tick(1); chk_irq(1'b0, "R6 edge after two");
      tick(1); chk_irq(1'b1, "R6 edge after three");
      pin_i[1] = 1'b0; tick(4);
      rd(A_STAT, 32'h2, "R6 edge held");
      wr(A_ACK, 32'h0);
      rd(A_STAT, 32'h2, "R7 zero ack bits no effect");
      wr(A_ACK, 32'h2);
      rd(A_STAT, 32'h0, "R7 ack clears");
      chk_irq(1'b0, "R7 irq after ack");
      pin_i[2] = 1'b1; tick(4);
      rd(A_STAT, 32'h0, "R6 rising ignored when falling selected");
      pin_i[2] = 1'b0; tick(4);
      rd(A_STAT, 32'h4, "R6 falling edge latched");
      wr(A_ACK, 32'h4);
      rd(A_STAT, 32'h0, "R7 ack pin2");
      // R11 polarity change on steady input
      pin_i[3] = 1'b1; tick(4);
      wr(A_PSET, 32'h8); tick(4);
      rd(A_STAT, 32'h0, "R11 pol set no event");
      wr(A_PCLR, 32'h8); tick(4);
      rd(A_STAT, 32'h0, "R11 pol clear no event");
      // R7 ack in the same cycle as a new edge
      pin_i[1] = 1'b1;
      tick(2);
      wr(A_ACK, 32'h2);
      rd(A_STAT, 32'h2, "R7 new edge wins over ack");
      wr(A_ACK, 32'h2);
      pin_i[1] = 1'b0;
      rd(A_STAT, 32'h0, "R7 second ack clears");
      // R8 soft trigger
      wr(A_FSET, 32'h4);
      chk_irq(1'b1, "R8 soft raises irq");
      rd(A_STAT, 32'h4, "R8 soft status");
      rd(A_SOFT, 32'h4, "R8 soft readback");
      wr(A_FCLR, 32'h4);
      rd(A_STAT, 32'h0, "R8 soft cleared");
      chk_irq(1'b0, "R8 irq after soft clear");
      wr(A_FSET, 32'h20);
      rd(A_STAT, 32'h0, "R4 soft on disabled pin");
      rd(A_SOFT, 32'h20, "R8 soft kept while disabled");
      wr(A_FCLR, 32'h20);
      rd(A_ACK, 32'h0, "R10 ack window reads 0");
      // R2 second port, pin 33
      wr(A_PSET + 11'h4, 32'h2);
      wr(A_MCLR + 11'h4, 32'h2);
      pin_i[33] = 1'b1; tick(4);
      rd(A_STAT + 11'h4, 32'h2, "R2 pin33 in word1 bit1");
      rd(A_STAT, 32'h0, "R2 word0 untouched");
      chk_irq(1'b1, "R9 irq from port1");
      wr(A_ACK + 11'h4, 32'h2);
      rd(A_STAT + 11'h4, 32'h0, "R7 ack word1");
      chk_irq(1'b0, "R9 irq low at end");
      tick(3);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not end, actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule